// File: doc/BRIEF.md
# Eight-Bit Accumulator-Machine Opcode Predecoder

This block takes the first byte of an instruction for a classic eight-bit accumulator machine and turns it into a control bundle. The bundle gives the instruction kind, the raw register and register-pair fields, the branch condition, the restart target address, the number of bytes the instruction occupies, and two flags. One flag marks a memory operand reached through the H:L pair. The other marks the flags-and-accumulator word taking the place of the stack pointer in pushes and pops. Byte values that the machine does not define are reported as illegal. They are not treated as aliases of their neighbours.

A fetch unit presents an opcode together with a one-cycle strobe. The bundle appears on the registered outputs on the next clock edge. The output strobe marks it for one cycle, and the bundle then holds until the next strobe. The block does not fetch operand bytes, execute anything, or track interrupt state. The fetch unit uses the reported length to know how many operand bytes follow.

Top module: `insn_predecode`

## Requirements
- R1: `dec_dst` carries opcode bits 5:3, `dec_src` bits 2:0 and `dec_pair` bits 5:4. Register codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at H:L, 7=A. Pair codes are 0=BC, 1=DE, 2=HL, 3=SP.
- R2: Every byte of the form 01xxxxxx is a register move (kind 1), except 0x76, which is a halt (kind 35).
- R3: The indirect store 00pp0010 and indirect load 00pp1010 (kinds 9 and 8) exist only for pair 0 or 1. For the other pairs, 0x22 stores HL direct (7), 0x2A loads HL direct (6), 0x32 stores A direct (5) and 0x3A loads A direct (4).
- R4: For conditional returns 11ccc000, jumps 11ccc010 and calls 11ccc100, `dec_cond` equals ccc. For every other opcode it is 0.
- R5: For the restart form 11nnn111, `dec_rst_vec` equals nnn*8. For every other opcode it is 0.
- R6: `dec_len` is 3 for pair-immediate loads, direct loads and stores, and jumps and calls (plain or conditional). It is 2 for register-immediate loads, ALU-immediate ops, IN (0xDB) and OUT (0xD3). It is 1 for everything else.
- R7: `dec_mem` is set when a register field that the instruction uses equals 6. This covers moves (either field), ALU register ops (source), and increment, decrement and immediate loads (destination). It is never set for the halt.
- R8: `dec_psw` is set only for push 0xF5 and pop 0xF1.
- R9: The twelve undefined bytes 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38, 0xCB, 0xD9, 0xDD, 0xED and 0xFD set `dec_illegal`, report kind 36 and report length 1.
- R10: `dec_valid` is high in the cycle after `in_valid` was high and low otherwise. The bundle then describes the opcode that was sampled with the strobe.
- R11: While `in_valid` is low, every bundle output keeps its value, whatever `in_op` carries.
- R12: While reset is asserted, and until the first strobe after it, every output is 0.
- R13: `dec_kind` codes are: NOP 0, move 1, reg-immediate 2, pair-immediate 3, load A direct 4, store A direct 5, load HL direct 6, store HL direct 7, indirect load 8, indirect store 9, swap DE/HL 10, ALU reg 11, ALU immediate 12, increment 13, decrement 14, pair increment 15, pair decrement 16, pair add to HL 17, accumulator/carry op 00xxx111 18, jump 19, conditional jump 20, call 21, conditional call 22, return 23, conditional return 24, restart 25, jump via HL 26, push 27, pop 28, swap stack top with HL 29, SP from HL 30, IN 31, OUT 32, enable interrupts 33, disable interrupts 34, halt 35, illegal 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Opcode strobe |
| in_op | input | 8 | Opcode byte |
| dec_valid | output | 1 | Bundle updated this cycle |
| dec_kind | output | 6 | Instruction kind code (R13) |
| dec_dst | output | 3 | Destination/operation field |
| dec_src | output | 3 | Source field |
| dec_pair | output | 2 | Register-pair field |
| dec_cond | output | 3 | Branch condition, 0 if unconditional |
| dec_rst_vec | output | VEC_W | Restart target address |
| dec_len | output | 2 | Instruction length in bytes |
| dec_mem | output | 1 | Memory operand through H:L |
| dec_psw | output | 1 | Flags:A word replaces SP |
| dec_illegal | output | 1 | Undefined opcode |

## Verification
Two functions can fall in the same cycle: a fresh decode when the strobe is high, and holding the bundle when the strobe is low while the opcode bus keeps changing. The bench first sweeps all 256 bytes with the strobe held high. It then sweeps them again, with each strobe followed by an idle cycle that drives the bitwise inverse of the byte. An output that follows that inverted byte is a hold failure. Every cycle is compared against a reference model that is built from bit-pattern matching rather than from the octal field split the RTL uses.

// File: rtl/insn_predecode_pkg.sv
package insn_predecode_pkg;
  localparam int KIND_W = 6;
  localparam int OP_W   = 8;

  typedef enum logic [KIND_W-1:0] {
    K_NOP     = 6'd0,  K_MOVE    = 6'd1,  K_LOADI   = 6'd2,  K_PAIRI   = 6'd3,
    K_LDACC   = 6'd4,  K_STACC   = 6'd5,  K_LDHL    = 6'd6,  K_STHL    = 6'd7,
    K_LDIND   = 6'd8,  K_STIND   = 6'd9,  K_SWAPDH  = 6'd10, K_ALUREG  = 6'd11,
    K_ALUIMM  = 6'd12, K_INC     = 6'd13, K_DEC     = 6'd14, K_PINC    = 6'd15,
    K_PDEC    = 6'd16, K_PADD    = 6'd17, K_ACCOP   = 6'd18, K_JUMP    = 6'd19,
    K_JUMPC   = 6'd20, K_CALL    = 6'd21, K_CALLC   = 6'd22, K_RET     = 6'd23,
    K_RETC    = 6'd24, K_RESTART = 6'd25, K_JUMPHL  = 6'd26, K_PUSH    = 6'd27,
    K_POP     = 6'd28, K_SWAPSP  = 6'd29, K_LDSP    = 6'd30, K_IN      = 6'd31,
    K_OUT     = 6'd32, K_ENINT   = 6'd33, K_DISINT  = 6'd34, K_HALT    = 6'd35,
    K_BAD     = 6'd36
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] dst;
    logic [2:0] src;
    logic [1:0] pair;
    logic [2:0] cond;
    logic [1:0] len;
    logic       mem;
    logic       psw;
    logic       bad;
  } bundle_t;
endpackage

// File: rtl/pd_kind_map.sv
module pd_kind_map
  import insn_predecode_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output kind_e           kind
);
  logic [1:0] x;
  logic [2:0] y;
  logic [2:0] z;
  logic [1:0] p;
  logic       q;

  assign x = op[7:6];
  assign y = op[5:3];
  assign z = op[2:0];
  assign p = y[2:1];
  assign q = y[0];

  always_comb begin
    kind = K_BAD;
    case (x)
      2'd0: begin
        case (z)
          3'd0: kind = (y == 3'd0) ? K_NOP : K_BAD;
          3'd1: kind = q ? K_PADD : K_PAIRI;
          3'd2: begin
            if (!p[1]) begin
              kind = q ? K_LDIND : K_STIND;
            end else begin
              case ({p[0], q})
                2'b00:   kind = K_STHL;
                2'b01:   kind = K_LDHL;
                2'b10:   kind = K_STACC;
                default: kind = K_LDACC;
              endcase
            end
          end
          3'd3: kind = q ? K_PDEC : K_PINC;
          3'd4: kind = K_INC;
          3'd5: kind = K_DEC;
          3'd6: kind = K_LOADI;
          default: kind = K_ACCOP;
        endcase
      end
      2'd1: kind = (y == 3'd6 && z == 3'd6) ? K_HALT : K_MOVE;
      2'd2: kind = K_ALUREG;
      default: begin
        case (z)
          3'd0: kind = K_RETC;
          3'd1: begin
            if (!q) begin
              kind = K_POP;
            end else begin
              case (p)
                2'd0:    kind = K_RET;
                2'd1:    kind = K_BAD;
                2'd2:    kind = K_JUMPHL;
                default: kind = K_LDSP;
              endcase
            end
          end
          3'd2: kind = K_JUMPC;
          3'd3: begin
            case (y)
              3'd0:    kind = K_JUMP;
              3'd1:    kind = K_BAD;
              3'd2:    kind = K_OUT;
              3'd3:    kind = K_IN;
              3'd4:    kind = K_SWAPSP;
              3'd5:    kind = K_SWAPDH;
              3'd6:    kind = K_DISINT;
              default: kind = K_ENINT;
            endcase
          end
          3'd4: kind = K_CALLC;
          3'd5: kind = !q ? K_PUSH : ((p == 2'd0) ? K_CALL : K_BAD);
          3'd6: kind = K_ALUIMM;
          default: kind = K_RESTART;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/pd_attr.sv
module pd_attr
  import insn_predecode_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic [5:0]       op_lo,
  input  kind_e            kind,
  output logic [1:0]       len,
  output logic             mem,
  output logic             psw,
  output logic [2:0]       cond,
  output logic [VEC_W-1:0] rst_vec
);
  localparam logic [2:0] REG_M  = 3'd6;
  localparam logic [1:0] PAIR_W = 2'd3;

  logic dst_m;
  logic src_m;

  assign dst_m = (op_lo[5:3] == REG_M);
  assign src_m = (op_lo[2:0] == REG_M);

  always_comb begin
    case (kind)
      K_PAIRI, K_LDACC, K_STACC, K_LDHL, K_STHL,
      K_JUMP, K_JUMPC, K_CALL, K_CALLC:   len = 2'd3;
      K_LOADI, K_ALUIMM, K_IN, K_OUT:     len = 2'd2;
      default:                            len = 2'd1;
    endcase
  end

  always_comb begin
    case (kind)
      K_MOVE:                  mem = dst_m | src_m;
      K_ALUREG:                mem = src_m;
      K_INC, K_DEC, K_LOADI:   mem = dst_m;
      default:                 mem = 1'b0;
    endcase
  end

  assign psw = ((kind == K_PUSH) || (kind == K_POP)) && (op_lo[5:4] == PAIR_W);

  always_comb begin
    case (kind)
      K_JUMPC, K_CALLC, K_RETC: cond = op_lo[5:3];
      default:                  cond = 3'd0;
    endcase
  end

  always_comb begin
    rst_vec = '0;
    if (kind == K_RESTART) rst_vec[5:3] = op_lo[5:3];
  end
endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import insn_predecode_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_op,
  output logic              dec_valid,
  output logic [5:0]        dec_kind,
  output logic [2:0]        dec_dst,
  output logic [2:0]        dec_src,
  output logic [1:0]        dec_pair,
  output logic [2:0]        dec_cond,
  output logic [VEC_W-1:0]  dec_rst_vec,
  output logic [1:0]        dec_len,
  output logic              dec_mem,
  output logic              dec_psw,
  output logic              dec_illegal
);
  kind_e            kind_c;
  logic [1:0]       len_c;
  logic             mem_c;
  logic             psw_c;
  logic [2:0]       cond_c;
  logic [VEC_W-1:0] vec_c;

  bundle_t          bun_q, bun_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vld_q, vld_d;

  pd_kind_map u_kind (
    .op   (in_op),
    .kind (kind_c)
  );

  pd_attr #(.VEC_W(VEC_W)) u_attr (
    .op_lo   (in_op[5:0]),
    .kind    (kind_c),
    .len     (len_c),
    .mem     (mem_c),
    .psw     (psw_c),
    .cond    (cond_c),
    .rst_vec (vec_c)
  );

  always_comb begin
    vld_d = in_valid;
    bun_d = bun_q;
    vec_d = vec_q;
    if (in_valid) begin
      bun_d.kind = kind_c;
      bun_d.dst  = in_op[5:3];
      bun_d.src  = in_op[2:0];
      bun_d.pair = in_op[5:4];
      bun_d.cond = cond_c;
      bun_d.len  = len_c;
      bun_d.mem  = mem_c;
      bun_d.psw  = psw_c;
      bun_d.bad  = (kind_c == K_BAD);
      vec_d      = vec_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bun_q <= '0;
      vec_q <= '0;
    end else begin
      vld_q <= vld_d;
      bun_q <= bun_d;
      vec_q <= vec_d;
    end
  end

  assign dec_valid   = vld_q;
  assign dec_kind    = bun_q.kind;
  assign dec_dst     = bun_q.dst;
  assign dec_src     = bun_q.src;
  assign dec_pair    = bun_q.pair;
  assign dec_cond    = bun_q.cond;
  assign dec_rst_vec = vec_q;
  assign dec_len     = bun_q.len;
  assign dec_mem     = bun_q.mem;
  assign dec_psw     = bun_q.psw;
  assign dec_illegal = bun_q.bad;

  // R9
  illegal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_illegal |-> (dec_len == 2'd1 && dec_kind == K_BAD));

  // R8
  psw_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_psw |-> (dec_kind == K_PUSH || dec_kind == K_POP));

  // R7
  halt_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_kind == K_HALT) |-> !dec_mem);

  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_len != 2'd0));

  // R10
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dec_valid);

  // R10
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !dec_valid);

  // R11
  hold_bundle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dec_kind) && $stable(dec_len) && $stable(dec_rst_vec)));

  // R5
  vec_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rst_vec != '0) |-> (dec_kind == K_RESTART));
endmodule

// File: tb/insn_predecode_bench.sv
module insn_predecode_bench;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_op = 8'h00;
  logic          dec_valid;
  logic [5:0]    dec_kind;
  logic [2:0]    dec_dst, dec_src, dec_cond;
  logic [1:0]    dec_pair, dec_len;
  logic [VW-1:0] dec_rst_vec;
  logic          dec_mem, dec_psw, dec_illegal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  insn_predecode #(.VEC_W(VW)) u_insn_predecode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .dec_valid(dec_valid), .dec_kind(dec_kind), .dec_dst(dec_dst),
    .dec_src(dec_src), .dec_pair(dec_pair), .dec_cond(dec_cond),
    .dec_rst_vec(dec_rst_vec), .dec_len(dec_len), .dec_mem(dec_mem),
    .dec_psw(dec_psw), .dec_illegal(dec_illegal)
  );

  // expected state (R12: everything zero out of reset)
  int e_valid = 0, e_kind = 0, e_dst = 0, e_src = 0, e_pair = 0;
  int e_cond = 0, e_vec = 0, e_len = 0, e_mem = 0, e_psw = 0, e_bad = 0;
  int e_op = 0;

  function automatic int ref_kind(input logic [7:0] o);
    if (o == 8'h76) return 35;
    casez (o)
      8'b00000000: return 0;
      8'b00???000: return 36;
      8'b00??0001: return 3;
      8'b00??1001: return 17;
      8'b000?0010: return 9;
      8'b000?1010: return 8;
      8'h22:       return 7;
      8'h2A:       return 6;
      8'h32:       return 5;
      8'h3A:       return 4;
      8'b00??0011: return 15;
      8'b00??1011: return 16;
      8'b00???100: return 13;
      8'b00???101: return 14;
      8'b00???110: return 2;
      8'b00???111: return 18;
      8'b01??????: return 1;
      8'b10??????: return 11;
      8'b11???000: return 24;
      8'b11??0001: return 28;
      8'hC9:       return 23;
      8'hE9:       return 26;
      8'hF9:       return 30;
      8'b11???010: return 20;
      8'hC3:       return 19;
      8'hD3:       return 32;
      8'hDB:       return 31;
      8'hE3:       return 29;
      8'hEB:       return 10;
      8'hF3:       return 34;
      8'hFB:       return 33;
      8'b11???100: return 22;
      8'b11??0101: return 27;
      8'hCD:       return 21;
      8'b11???110: return 12;
      8'b11???111: return 25;
      default:     return 36;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%02h actual=%0d expected=%0d", tag, e_op[7:0], act, exp);
    end
  endtask

  task automatic compare_all();
    string kt;
    kt = "R13 kind";
    if (e_valid == 0) kt = "R11 hold kind";
    else if (e_op[7:6] == 2'b01) kt = "R2 kind";
    else if (e_op[7:6] == 2'b00 && e_op[2:0] == 3'b010) kt = "R3 kind";
    chk("R10 valid", int'(dec_valid), e_valid);
    chk(kt, int'(dec_kind), e_kind);
    chk("R1 dst", int'(dec_dst), e_dst);
    chk("R1 src", int'(dec_src), e_src);
    chk("R1 pair", int'(dec_pair), e_pair);
    chk("R4 cond", int'(dec_cond), e_cond);
    chk("R5 rst_vec", int'(dec_rst_vec), e_vec);
    chk("R6 len", int'(dec_len), e_len);
    chk("R7 mem", int'(dec_mem), e_mem);
    chk("R8 psw", int'(dec_psw), e_psw);
    chk("R9 illegal", int'(dec_illegal), e_bad);
  endtask

  task automatic model(input bit v, input logic [7:0] o);
    int k;
    e_valid = v ? 1 : 0;
    if (!v) return;
    k = ref_kind(o);
    e_op   = int'(o);
    e_kind = k;
    e_dst  = int'(o[5:3]);
    e_src  = int'(o[2:0]);
    e_pair = int'(o[5:4]);
    e_cond = (k == 20 || k == 22 || k == 24) ? int'(o[5:3]) : 0;
    e_vec  = (k == 25) ? int'(o[5:3]) * 8 : 0;
    case (k)
      3, 4, 5, 6, 7, 19, 20, 21, 22: e_len = 3;
      2, 12, 31, 32:                 e_len = 2;
      default:                       e_len = 1;
    endcase
    case (k)
      1:         e_mem = (o[5:3] == 3'd6 || o[2:0] == 3'd6) ? 1 : 0;
      11:        e_mem = (o[2:0] == 3'd6) ? 1 : 0;
      2, 13, 14: e_mem = (o[5:3] == 3'd6) ? 1 : 0;
      default:   e_mem = 0;
    endcase
    e_psw = (o == 8'hF5 || o == 8'hF1) ? 1 : 0;
    e_bad = (k == 36) ? 1 : 0;
  endtask

  task automatic step(input bit v, input logic [7:0] o);
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_op    = o;
    model(v, o);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R12: reset state, with opcode bus active during reset
    in_op = 8'hC7;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    e_op = 8'hC7;
    compare_all();
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 8'h3A);   // R12: still zero after release, no strobe yet
    // sweep with strobe held high
    for (int i = 0; i < 256; i++) step(1'b1, 8'(i));
    // sweep with idle cycles driving inverted bytes (R11)
    for (int i = 0; i < 256; i++) begin
      step(1'b1, 8'(i));
      step(1'b0, ~8'(i));
    end
    step(1'b0, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule